// File: doc/BRIEF.md
# NAND Command and Address Latch Cycle Generator

This block turns queued beats into NAND command-latch or address-latch write cycles on the external control pins. A beat carries one data word, a chip-select index and a flag that says whether the word is a command or an address. The block takes one beat when it is idle. It copies that chip select's timing set, then runs one asynchronous write cycle in which chip enable, the latch enable and write enable each follow their own on/off tick counts.

Ticks are counted from the first clock cycle after the beat is taken. A command beat pulses CLE and an address beat pulses ALE, with identical timing. The read strobe is never asserted. When the cycle ends the block raises a one-tick done pulse with every pin idle, then it is ready for the next beat. Six flattened timing vectors supply the on and off ticks for every chip select, one TICK_W-wide field per chip select, with chip select k at bits [k*TICK_W +: TICK_W].

Top module: `nandLatchCycleGen`

## Requirements
- R1: After reset every nCe line is high, cle and ale are low, nWe and nRe are high, dataOe and done are low, and beatReady is high.
- R2: During a cycle, nCe bit k (k being the beat's chip select) is low exactly on ticks t with csOn <= t < csOff. Every other nCe bit stays high. Tick 0 is the first clock after the beat is taken.
- R3: A beat with beatIsAddr = 0 (command) drives cle high exactly on ticks with leOn <= t < leOff, and ale stays low.
- R4: A beat with beatIsAddr = 1 (address) drives ale high exactly on ticks with leOn <= t < leOff, and cle stays low.
- R5: nWe is low exactly on ticks with weOn <= t < weOff.
- R6: nRe stays high at all times.
- R7: dataOe is high exactly on ticks t < max(weOff, leOff), and dataOut then equals the beat's data.
- R8: A cycle lasts max(csOff, leOff, weOff) ticks, or one tick when all three are zero. done is high for exactly the one clock that follows the last tick, with all pins idle in that clock.
- R9: beatReady is low from the clock after a beat is taken through the done clock. It is high again in the clock after done, so two cycles are always separated by at least one idle tick.
- R10: Timing comes from the fields of the beat's chip select and is captured when the beat is taken. Changes to the timing inputs during a cycle have no effect on that cycle.
- R11: A window whose on tick is not below its off tick leaves its pin inactive for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rstN | input | 1 | Active-low asynchronous reset |
| beatValid | input | 1 | A beat is offered |
| beatReady | output | 1 | Block is idle and takes the offered beat |
| beatData | input | DATA_W | Command or address value |
| beatCs | input | CS_W | Chip-select index of the beat |
| beatIsAddr | input | 1 | 1 = address cycle, 0 = command cycle |
| tCsOn | input | NUM_CS*TICK_W | Chip-enable on tick per chip select |
| tCsOff | input | NUM_CS*TICK_W | Chip-enable off tick per chip select |
| tLeOn | input | NUM_CS*TICK_W | Latch-enable on tick per chip select |
| tLeOff | input | NUM_CS*TICK_W | Latch-enable off tick per chip select |
| tWeOn | input | NUM_CS*TICK_W | Write-enable on tick per chip select |
| tWeOff | input | NUM_CS*TICK_W | Write-enable off tick per chip select |
| nCe | output | NUM_CS | Active-low chip enables |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| nWe | output | 1 | Active-low write enable |
| nRe | output | 1 | Active-low read enable, held inactive |
| dataOut | output | DATA_W | Data bus value |
| dataOe | output | 1 | Data bus output enable |
| done | output | 1 | One-tick pulse after each cycle |

## Verification
The hardest case to reach is a timing change that arrives while a cycle is in flight. The block reads the timing inputs only in the clock it takes a beat, so a wrong design differs only when the inputs move after that clock. The bench starts a cycle and rewrites that chip select's timing fields at tick 0. It then compares every later tick against the values saved before the beat. It also covers degenerate windows: all-zero times, an empty write window, and an end set by each of the three off times in turn.

// File: rtl/nandCyclePkg.sv
package nandCyclePkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2
  } cycState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture beat and timing, clear tick count
    logic active;  // a write cycle is in progress
  } cycStrobes_t;

endpackage

// File: rtl/nandCycleCtrl.sv
module nandCycleCtrl
  import nandCyclePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        beatValid,
  input  logic        lastTick,
  output logic        beatReady,
  output logic        done,
  output cycStrobes_t strobes
);

  cycState_t state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (beatValid) stateNext = ST_RUN;
      ST_RUN:  if (lastTick)  stateNext = ST_GAP;
      ST_GAP:                 stateNext = ST_IDLE;
      default:                stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign beatReady      = (state == ST_IDLE);
  assign done           = (state == ST_GAP);
  assign strobes.load   = beatValid && beatReady;
  assign strobes.active = (state == ST_RUN);

  // a taken beat closes the intake on the next clock
  assert_busy_after_take_R9: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && beatReady) |=> !beatReady);

  // done is a single-clock pulse followed by readiness
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && beatReady));

endmodule

// File: rtl/nandCycleDatapath.sv
module nandCycleDatapath
  import nandCyclePkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int DATA_W = 8,
  parameter int TICK_W = 4,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int TV_W  = NUM_CS * TICK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  cycStrobes_t       strobes,
  input  logic [DATA_W-1:0] beatData,
  input  logic [CS_W-1:0]   beatCs,
  input  logic              beatIsAddr,
  input  logic [TV_W-1:0]   tCsOn,
  input  logic [TV_W-1:0]   tCsOff,
  input  logic [TV_W-1:0]   tLeOn,
  input  logic [TV_W-1:0]   tLeOff,
  input  logic [TV_W-1:0]   tWeOn,
  input  logic [TV_W-1:0]   tWeOff,
  output logic              lastTick,
  output logic [NUM_CS-1:0] nCe,
  output logic              cle,
  output logic              ale,
  output logic              nWe,
  output logic              nRe,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  logic [DATA_W-1:0] capData;
  logic [CS_W-1:0]   capCs;
  logic              capIsAddr;
  logic [TICK_W-1:0] csOn, csOff, leOn, leOff, weOn, weOff;
  logic [TICK_W-1:0] tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capData   <= '0;
      capCs     <= '0;
      capIsAddr <= 1'b0;
      csOn      <= '0;
      csOff     <= '0;
      leOn      <= '0;
      leOff     <= '0;
      weOn      <= '0;
      weOff     <= '0;
      tick      <= '0;
    end else if (strobes.load) begin
      capData   <= beatData;
      capCs     <= beatCs;
      capIsAddr <= beatIsAddr;
      csOn      <= tCsOn [int'(beatCs)*TICK_W +: TICK_W];
      csOff     <= tCsOff[int'(beatCs)*TICK_W +: TICK_W];
      leOn      <= tLeOn [int'(beatCs)*TICK_W +: TICK_W];
      leOff     <= tLeOff[int'(beatCs)*TICK_W +: TICK_W];
      weOn      <= tWeOn [int'(beatCs)*TICK_W +: TICK_W];
      weOff     <= tWeOff[int'(beatCs)*TICK_W +: TICK_W];
      tick      <= '0;
    end else if (strobes.active) begin
      tick      <= tick + TICK_W'(1);
    end
  end

  // window tests for the current tick
  logic csWin, leWin, weWin;
  assign csWin = strobes.active && (tick >= csOn) && (tick < csOff);
  assign leWin = strobes.active && (tick >= leOn) && (tick < leOff);
  assign weWin = strobes.active && (tick >= weOn) && (tick < weOff);

  // end of cycle and end of data drive
  logic [TICK_W-1:0] dataEnd, maxOff, endTick;
  assign dataEnd  = (weOff > leOff) ? weOff : leOff;
  assign maxOff   = (csOff > dataEnd) ? csOff : dataEnd;
  assign endTick  = (maxOff == '0) ? TICK_W'(1) : maxOff;
  assign lastTick = strobes.active && (tick == endTick - TICK_W'(1));

  genvar k;
  generate
    for (k = 0; k < NUM_CS; k++) begin : gCe
      assign nCe[k] = !(csWin && (capCs == CS_W'(k)));
    end
  endgenerate

  assign cle     = leWin && !capIsAddr;
  assign ale     = leWin && capIsAddr;
  assign nWe     = !weWin;
  assign nRe     = 1'b1;
  assign dataOe  = strobes.active && (tick < dataEnd);
  assign dataOut = dataOe ? capData : '0;

  assert_single_ce_R2: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~nCe) <= 1);

  assert_latch_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(cle && ale));

  // the write strobe never falls on an undriven bus
  assert_we_with_data_R7: assert property (@(posedge clk) disable iff (!rstN)
    !nWe |-> dataOe);

  // pins rest when no cycle runs
  assert_idle_pins_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.active |-> (&nCe && nWe && !cle && !ale && !dataOe));

endmodule

// File: rtl/nandLatchCycleGen.sv
module nandLatchCycleGen
  import nandCyclePkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int DATA_W = 8,
  parameter int TICK_W = 4,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int TV_W  = NUM_CS * TICK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              beatValid,
  output logic              beatReady,
  input  logic [DATA_W-1:0] beatData,
  input  logic [CS_W-1:0]   beatCs,
  input  logic              beatIsAddr,
  input  logic [TV_W-1:0]   tCsOn,
  input  logic [TV_W-1:0]   tCsOff,
  input  logic [TV_W-1:0]   tLeOn,
  input  logic [TV_W-1:0]   tLeOff,
  input  logic [TV_W-1:0]   tWeOn,
  input  logic [TV_W-1:0]   tWeOff,
  output logic [NUM_CS-1:0] nCe,
  output logic              cle,
  output logic              ale,
  output logic              nWe,
  output logic              nRe,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              done
);

  cycStrobes_t strobes;
  logic        lastTick;

  nandCycleCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .beatValid (beatValid),
    .lastTick  (lastTick),
    .beatReady (beatReady),
    .done      (done),
    .strobes   (strobes)
  );

  nandCycleDatapath #(
    .NUM_CS (NUM_CS),
    .DATA_W (DATA_W),
    .TICK_W (TICK_W)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .beatData   (beatData),
    .beatCs     (beatCs),
    .beatIsAddr (beatIsAddr),
    .tCsOn      (tCsOn),
    .tCsOff     (tCsOff),
    .tLeOn      (tLeOn),
    .tLeOff     (tLeOff),
    .tWeOn      (tWeOn),
    .tWeOff     (tWeOff),
    .lastTick   (lastTick),
    .nCe        (nCe),
    .cle        (cle),
    .ale        (ale),
    .nWe        (nWe),
    .nRe        (nRe),
    .dataOut    (dataOut),
    .dataOe     (dataOe)
  );

  assert_read_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cle || ale || !nWe) |-> nRe);

endmodule

// File: tb/nandLatchCycleGen_test.sv
`timescale 1ns/1ps
module nandLatchCycleGen_test;
  localparam int NUM_CS = 8;
  localparam int DATA_W = 8;
  localparam int TICK_W = 4;
  localparam int CS_W   = 3;
  localparam int TV_W   = NUM_CS * TICK_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic              beatValid = 1'b0;
  logic              beatReady;
  logic [DATA_W-1:0] beatData = '0;
  logic [CS_W-1:0]   beatCs = '0;
  logic              beatIsAddr = 1'b0;
  logic [TV_W-1:0]   tCsOn = '0, tCsOff = '0, tLeOn = '0, tLeOff = '0, tWeOn = '0, tWeOff = '0;
  logic [NUM_CS-1:0] nCe;
  logic              cle, ale, nWe, nRe, dataOe, done;
  logic [DATA_W-1:0] dataOut;

  nandLatchCycleGen #(.NUM_CS(NUM_CS), .DATA_W(DATA_W), .TICK_W(TICK_W)) uut (
    .clk(clk), .rstN(rstN), .beatValid(beatValid), .beatReady(beatReady),
    .beatData(beatData), .beatCs(beatCs), .beatIsAddr(beatIsAddr),
    .tCsOn(tCsOn), .tCsOff(tCsOff), .tLeOn(tLeOn), .tLeOff(tLeOff),
    .tWeOn(tWeOn), .tWeOff(tWeOff), .nCe(nCe), .cle(cle), .ale(ale),
    .nWe(nWe), .nRe(nRe), .dataOut(dataOut), .dataOe(dataOe), .done(done));

  int errors = 0;
  int checks = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic setTiming(int cs, int cOn, int cOff, int lOn, int lOff, int wOn, int wOff);
    tCsOn [cs*TICK_W +: TICK_W] = TICK_W'(cOn);
    tCsOff[cs*TICK_W +: TICK_W] = TICK_W'(cOff);
    tLeOn [cs*TICK_W +: TICK_W] = TICK_W'(lOn);
    tLeOff[cs*TICK_W +: TICK_W] = TICK_W'(lOff);
    tWeOn [cs*TICK_W +: TICK_W] = TICK_W'(wOn);
    tWeOff[cs*TICK_W +: TICK_W] = TICK_W'(wOff);
  endtask

  // runs one beat and checks every tick against the saved timing
  task automatic runBeat(string scen, int cs, bit isAddr, logic [DATA_W-1:0] data, bit disturb);
    int cOn  = int'(tCsOn [cs*TICK_W +: TICK_W]);
    int cOff = int'(tCsOff[cs*TICK_W +: TICK_W]);
    int lOn  = int'(tLeOn [cs*TICK_W +: TICK_W]);
    int lOff = int'(tLeOff[cs*TICK_W +: TICK_W]);
    int wOn  = int'(tWeOn [cs*TICK_W +: TICK_W]);
    int wOff = int'(tWeOff[cs*TICK_W +: TICK_W]);
    int dEnd = (wOff > lOff) ? wOff : lOff;
    int endT = (cOff > dEnd) ? cOff : dEnd;
    if (endT == 0) endT = 1;
    @(negedge clk);
    chk("R9", {scen, " ready before beat"}, 32'(beatReady), 32'd1);
    beatValid = 1'b1; beatCs = CS_W'(cs); beatIsAddr = isAddr; beatData = data;
    @(negedge clk);
    beatValid = 1'b0;
    for (int t = 0; t < endT; t++) begin
      bit ceW = (t >= cOn) && (t < cOff);
      bit leW = (t >= lOn) && (t < lOff);
      bit weW = (t >= wOn) && (t < wOff);
      bit oe  = t < dEnd;
      logic [NUM_CS-1:0] expCe = ceW ? ~(NUM_CS'(1) << cs) : '1;
      chk("R2", {scen, " nCe"}, 32'(nCe), 32'(expCe));
      chk("R3", {scen, " cle"}, 32'(cle), 32'(leW && !isAddr));
      chk("R4", {scen, " ale"}, 32'(ale), 32'(leW && isAddr));
      chk("R5", {scen, " nWe"}, 32'(nWe), 32'(!weW));
      chk("R6", {scen, " nRe"}, 32'(nRe), 32'd1);
      chk("R7", {scen, " dataOe"}, 32'(dataOe), 32'(oe));
      if (oe) chk("R7", {scen, " dataOut"}, 32'(dataOut), 32'(data));
      chk("R9", {scen, " ready while busy"}, 32'(beatReady), 32'd0);
      chk("R8", {scen, " done early"}, 32'(done), 32'd0);
      if (disturb && t == 0) setTiming(cs, 0, 1, 0, 0, 0, 1);
      @(negedge clk);
    end
    chk("R8", {scen, " done pulse"}, 32'(done), 32'd1);
    chk("R8", {scen, " idle pins at done"},
        32'({nCe, cle, ale, nWe, dataOe}), 32'({{NUM_CS{1'b1}}, 1'b0, 1'b0, 1'b1, 1'b0}));
    chk("R9", {scen, " ready at done"}, 32'(beatReady), 32'd0);
    @(negedge clk);
    chk("R8", {scen, " done ends"}, 32'(done), 32'd0);
    chk("R9", {scen, " ready after done"}, 32'(beatReady), 32'd1);
  endtask

  task automatic testReset();
    chk("R1", "reset nCe", 32'(nCe), 32'hFF);
    chk("R1", "reset latches/strobes", 32'({cle, ale, nWe, nRe, dataOe, done}), 32'b001100);
    chk("R1", "reset ready", 32'(beatReady), 32'd1);
  endtask

  task automatic testCommand();
    setTiming(0, 0, 6, 1, 5, 2, 4);
    runBeat("command cs0", 0, 1'b0, 8'h70, 1'b0);
  endtask

  task automatic testAddress();
    setTiming(5, 1, 5, 0, 3, 2, 7);
    runBeat("address cs5 end by nWe", 5, 1'b1, 8'hA5, 1'b0);
  endtask

  task automatic testEmptyWindow();
    // R11: equal on/off keeps nWe high, reversed window keeps nCe high
    setTiming(7, 4, 2, 1, 8, 3, 3);
    runBeat("R11 empty windows cs7", 7, 1'b0, 8'h3C, 1'b0);
  endtask

  task automatic testAllZero();
    setTiming(2, 0, 0, 0, 0, 0, 0);
    runBeat("zero times cs2 one tick", 2, 1'b1, 8'hFF, 1'b0);
  endtask

  task automatic testLatchedTiming();
    // R10: timing of cs3 rewritten during the cycle; old values must hold
    setTiming(3, 0, 9, 2, 6, 3, 5);
    setTiming(4, 0, 1, 0, 1, 0, 1);
    runBeat("R10 timing latched cs3", 3, 1'b0, 8'h5A, 1'b1);
    setTiming(3, 0, 9, 2, 6, 3, 5);
  endtask

  task automatic testPerCsSelect();
    // R10: two chip selects with different sets, back to back
    setTiming(1, 0, 3, 0, 2, 1, 2);
    setTiming(6, 2, 12, 4, 10, 5, 9);
    runBeat("R10 set of cs1", 1, 1'b1, 8'h12, 1'b0);
    runBeat("R10 set of cs6", 6, 1'b0, 8'hE0, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testCommand();
    testAddress();
    testEmptyWindow();
    testAllZero();
    testLatchedTiming();
    testPerCsSelect();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule